// File: doc/BRIEF.md
# Nibble-Polarity Event Detector with Interrupt

This block watches 32 asynchronous input lines, organised as four 8-bit ports, for a programmed level transition on each line. The lines fall into groups of four (nibbles). Every group has one polarity bit, so the four lines in a group all look for the same edge: rising or falling. A detected edge latches a sticky status bit for that line. Software clears a status bit by writing a one to it.

Each line also has an interrupt enable. One interrupt request output is raised whenever a latched line is also enabled and the global interrupt enable is set. Because polarity is shared by a nibble, detecting both edges of one signal takes two lines in different nibbles, wired to the same signal and given opposite polarities.

Detection and the interrupt only work while the extended-mode input is high. The register decode sits outside this block. It writes the polarity, enable, global-enable and clear values through plain write-enable/data pairs and reads the state back from the output ports. The inputs arrive from a debounce stage that is also outside the block, and each line passes through a two-flop synchroniser before edge detection.

Top module: `nibble_event_irq`

## Requirements
- R1: After reset all status bits are 0, `irq_o` is 0, all line enables are 0, the global enable is 0, and every polarity bit is 1 (rising).
- R2: A polarity bit of 1 sets a line's status bit on a low-to-high transition of that line and not on a high-to-low transition.
- R3: A polarity bit of 0 sets a line's status bit on a high-to-low transition of that line and not on a low-to-high transition.
- R4: Polarity bit g governs lines 4g to 4g+3 only; an edge on one line sets no other line's status.
- R5: An input change applied before a rising clock edge shows on `status_o` after the third rising edge, and not after the second.
- R6: A status bit stays at 1 until a clear write with a 1 in its position; clear-data bits at 0 leave status bits unchanged.
- R7: When a clear write and a detected event hit the same bit in the same cycle, the bit remains 1.
- R8: `irq_o` is 1 exactly when the extended mode and the global enable are both 1 and at least one line has both its status bit and its enable bit set.
- R9: While the extended mode is 0, edges set no status bits and `irq_o` is 0; an edge seen during that time is not reported once the mode returns to 1.
- R10: Two lines in different nibbles that carry one signal with opposite polarities together report both of its edges, one edge on each line.
- R11: `pol_o`, `ena_o` and `gie_o` return the last written polarity, enable and global-enable values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Extended mode active; enables detection and interrupt |
| line_in | input | 32 | Asynchronous (debounced) input lines |
| pol_we | input | 1 | Polarity write strobe |
| pol_wdata | input | 8 | Polarity per nibble, 1 = rising, 0 = falling |
| ena_we | input | 1 | Line-enable write strobe |
| ena_wdata | input | 32 | Per-line interrupt enable |
| gie_we | input | 1 | Global interrupt enable write strobe |
| gie_wdata | input | 1 | Global interrupt enable value |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 32 | Write-one-to-clear mask |
| status_o | output | 32 | Sticky event status per line |
| pol_o | output | 8 | Current polarity register |
| ena_o | output | 32 | Current line-enable register |
| gie_o | output | 1 | Current global interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Every one of the 32 lines is pulsed alone, once with its nibble set to rising and the other nibbles set to falling, and once the other way round. The rise and fall of each pulse tell the two polarities apart. The inverted polarity of the other nibbles shows up any wrong line-to-nibble mapping as a stray or missing status bit. Further targeted patterns cover the following:
- a clear that lands in the exact cycle of an event;
- clear masks with zeros over set bits;
- the combinations of enable, global enable and mode for the interrupt;
- an edge hidden while the mode is off;
- one signal fanned onto two opposite-polarity lines.

// File: rtl/nev_pkg.sv
package nev_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;

   function automatic int unsigned group_of(input int unsigned line, input int unsigned gw);
      return line / gw;
   endfunction

endpackage

// File: rtl/nev_sync.sv
module nev_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= async_in;
               for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
            end
         end

         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nev_edge.sv
module nev_edge
   import nev_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned GROUP_W = 4,
   localparam int unsigned GROUPS = WIDTH / GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  lvl,
   input  logic [GROUPS-1:0] grp_pol,
   output logic [WIDTH-1:0]  ev
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar i = 0; i < int'(WIDTH); i++) begin : g_line
         localparam int unsigned GRP = group_of(i, GROUP_W);
         edge_sel_e sel;
         assign sel   = edge_sel_e'(grp_pol[GRP]);
         assign ev[i] = (sel == EDGE_RISE) ? (lvl[i] & ~prev_q[i])
                                           : (~lvl[i] & prev_q[i]);
      end
   endgenerate

   // R2 R3
   edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(ev) & ~(prev_q ^ $past(prev_q))) == '0));

endmodule

// File: rtl/nev_status.sv
module nev_status #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [WIDTH-1:0] ev,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   input  logic [WIDTH-1:0] line_ena,
   input  logic             gie,
   output logic [WIDTH-1:0] status,
   output logic             irq
);

   logic [WIDTH-1:0] st_q;
   logic [WIDTH-1:0] keep_mask;
   logic [WIDTH-1:0] set_mask;

   assign keep_mask = clr_we ? ~clr_mask : '1;
   assign set_mask  = arm ? ev : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & keep_mask) | set_mask;
   end

   assign status = st_q;
   assign irq    = arm & gie & (|(st_q & line_ena));

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> (($past(st_q) & ~st_q) == '0));

   // R9
   armed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q & ~$past(st_q)) != '0) |-> $past(arm));

   // R7
   collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && arm && ((ev & clr_mask) != '0))
      |=> ((st_q & $past(ev & clr_mask)) == $past(ev & clr_mask)));

endmodule

// File: rtl/nibble_event_irq.sv
module nibble_event_irq #(
   parameter int unsigned PORTS       = 4,
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned GROUP_W     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LINES      = PORTS * PORT_W,
   localparam int unsigned GROUPS     = LINES / GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic [LINES-1:0]  line_in,
   input  logic              pol_we,
   input  logic [GROUPS-1:0] pol_wdata,
   input  logic              ena_we,
   input  logic [LINES-1:0]  ena_wdata,
   input  logic              gie_we,
   input  logic              gie_wdata,
   input  logic              clr_we,
   input  logic [LINES-1:0]  clr_wdata,
   output logic [LINES-1:0]  status_o,
   output logic [GROUPS-1:0] pol_o,
   output logic [LINES-1:0]  ena_o,
   output logic              gie_o,
   output logic              irq_o
);

   generate
      if (GROUP_W == 0 || (PORT_W % GROUP_W) != 0) begin : g_bad_group
         $error("GROUP_W must be nonzero and divide PORT_W");
      end
      if (PORTS == 0) begin : g_bad_ports
         $error("PORTS must be at least 1");
      end
   endgenerate

   logic [GROUPS-1:0] pol_q;
   logic [LINES-1:0]  ena_q;
   logic              gie_q;
   logic [LINES-1:0]  lvl;
   logic [LINES-1:0]  ev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q <= '1;
         ena_q <= '0;
         gie_q <= 1'b0;
      end else begin
         if (pol_we) pol_q <= pol_wdata;
         if (ena_we) ena_q <= ena_wdata;
         if (gie_we) gie_q <= gie_wdata;
      end
   end

   nev_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_in),
      .sync_out (lvl)
   );

   nev_edge #(.WIDTH(LINES), .GROUP_W(GROUP_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .grp_pol (pol_q),
      .ev      (ev)
   );

   nev_status #(.WIDTH(LINES)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (ext_mode),
      .ev       (ev),
      .clr_we   (clr_we),
      .clr_mask (clr_wdata),
      .line_ena (ena_q),
      .gie      (gie_q),
      .status   (status_o),
      .irq      (irq_o)
   );

   assign pol_o = pol_q;
   assign ena_o = ena_q;
   assign gie_o = gie_q;

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ext_mode && gie_q && ((status_o & ena_q) != '0)));

   // R11
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pol_we |=> (pol_o == $past(pol_wdata)));

endmodule

// File: tb/nibble_event_irq_test.sv
module nibble_event_irq_test;

   localparam int LINES  = 32;
   localparam int GROUPS = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ext_mode;
   logic [LINES-1:0]  line_in;
   logic              pol_we;
   logic [GROUPS-1:0] pol_wdata;
   logic              ena_we;
   logic [LINES-1:0]  ena_wdata;
   logic              gie_we;
   logic              gie_wdata;
   logic              clr_we;
   logic [LINES-1:0]  clr_wdata;
   logic [LINES-1:0]  status_o;
   logic [GROUPS-1:0] pol_o;
   logic [LINES-1:0]  ena_o;
   logic              gie_o;
   logic              irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   nibble_event_irq uut (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .line_in(line_in),
      .pol_we(pol_we), .pol_wdata(pol_wdata), .ena_we(ena_we), .ena_wdata(ena_wdata),
      .gie_we(gie_we), .gie_wdata(gie_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
      .status_o(status_o), .pol_o(pol_o), .ena_o(ena_o), .gie_o(gie_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pol(input logic [GROUPS-1:0] v);
      pol_we = 1'b1; pol_wdata = v; ticks(1); pol_we = 1'b0;
   endtask

   task automatic set_ena(input logic [LINES-1:0] v);
      ena_we = 1'b1; ena_wdata = v; ticks(1); ena_we = 1'b0;
   endtask

   task automatic set_gie(input logic v);
      gie_we = 1'b1; gie_wdata = v; ticks(1); gie_we = 1'b0;
   endtask

   task automatic clear(input logic [LINES-1:0] v);
      clr_we = 1'b1; clr_wdata = v; ticks(1); clr_we = 1'b0; clr_wdata = '0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ext_mode = 1'b0; line_in = '0;
      pol_we = 1'b0; pol_wdata = '0; ena_we = 1'b0; ena_wdata = '0;
      gie_we = 1'b0; gie_wdata = 1'b0; clr_we = 1'b0; clr_wdata = '0;
      ticks(4);
      rst_n = 1'b1;
      ticks(1);

      // R1 reset state
      chk("R1 status", status_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 ena", ena_o, 0);
      chk("R1 gie", gie_o, 0);
      chk("R1 pol", pol_o, 8'hFF);

      ext_mode = 1'b1;

      // R2 R3 R4 sweep: each line, its nibble at p, all other nibbles at !p
      for (int i = 0; i < LINES; i++) begin
         for (int p = 0; p < 2; p++) begin
            logic [GROUPS-1:0] pv;
            logic [LINES-1:0]  bit_i;
            bit_i = LINES'(1) << i;
            pv = (p == 1) ? (GROUPS'(1) << (i / 4)) : ~(GROUPS'(1) << (i / 4));
            set_pol(pv);
            line_in = bit_i;
            ticks(3);
            chk((p == 1) ? "R2 R4 rise on rising" : "R3 R4 rise on falling",
                status_o, (p == 1) ? bit_i : '0);
            line_in = '0;
            ticks(3);
            chk((p == 1) ? "R2 R4 fall after rise" : "R3 R4 fall on falling",
                status_o, bit_i);
            clear('1);
            chk("R6 clear all", status_o, 0);
         end
      end

      // R11 readback
      set_pol(8'hA5);
      chk("R11 pol readback", pol_o, 8'hA5);
      set_ena(32'h1234_5678);
      chk("R11 ena readback", ena_o, 32'h1234_5678);
      set_gie(1'b1);
      chk("R11 gie readback", gie_o, 1);

      // R5 latency: all rising
      set_pol('1);
      line_in = 32'h0000_0100;
      ticks(2);
      chk("R5 not after two edges", status_o, 0);
      ticks(1);
      chk("R5 after three edges", status_o, 32'h0000_0100);

      // R6 zero bits of clear keep status
      clear(32'hFFFF_FEFF);
      chk("R6 zero clear bit keeps", status_o, 32'h0000_0100);
      line_in = '0;
      ticks(3);

      // R8 interrupt gating (status bit 8 set)
      set_ena('0);
      chk("R8 irq masked by line enable", irq_o, 0);
      set_ena(32'h0000_0100);
      chk("R8 irq on enabled status", irq_o, 1);
      set_gie(1'b0);
      chk("R8 irq off by global enable", irq_o, 0);
      set_gie(1'b1);
      ext_mode = 1'b0;
      ticks(1);
      chk("R9 irq low outside mode", irq_o, 0);
      ext_mode = 1'b1;
      ticks(1);
      chk("R8 irq back", irq_o, 1);
      set_ena(32'h0000_0200);
      chk("R8 other line enabled only", irq_o, 0);
      clear('1);

      // R9 edge hidden while mode is off
      ext_mode = 1'b0;
      line_in = 32'h0001_0000;
      ticks(4);
      chk("R9 no set outside mode", status_o, 0);
      ext_mode = 1'b1;
      ticks(4);
      chk("R9 hidden edge not reported", status_o, 0);
      line_in = '0;
      ticks(4);

      // R7 clear coinciding with event on an already-set bit
      line_in = 32'h0000_0020;
      ticks(3);
      line_in = '0;
      ticks(3);
      chk("R7 precondition set", status_o, 32'h0000_0020);
      line_in = 32'h0000_0020;
      ticks(2);
      clr_we = 1'b1; clr_wdata = 32'h0000_0020;
      ticks(1);
      clr_we = 1'b0; clr_wdata = '0;
      chk("R7 event wins over clear", status_o, 32'h0000_0020);
      clear('1);
      chk("R7 later clear works", status_o, 0);
      line_in = '0;
      ticks(3);

      // R10 change of state on lines 0 (rising) and 4 (falling)
      set_pol(8'b1111_1101);
      line_in = 32'h0000_0011;
      ticks(3);
      chk("R10 rise seen on rising line", status_o, 32'h0000_0001);
      line_in = '0;
      ticks(3);
      chk("R10 fall seen on falling line", status_o, 32'h0000_0011);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule